// File: doc/BRIEF.md
# Local Interrupt Entry Dispatcher

This block holds the configuration entry for one local interrupt source and turns each event from that source into a signal toward the processor core. The entry has three fields. The first is a vector of `VEC_W` bits. The second is a 3-bit delivery-mode code. The third is a status flag that software can read but cannot write. When the source fires, the block decodes the mode code and raises exactly one of the following toward the core:

- a vectored interrupt that carries the entry's vector;
- a system-management pulse;
- a non-maskable pulse;
- an INIT pulse;
- a vectored interrupt whose vector comes from an external interrupt controller.

In the external-controller mode, the block opens an acknowledge cycle to that controller. It waits for the controller's valid strobe, then forwards the returned vector to the core with a one-cycle valid pulse. The vector is flagged as externally sourced.

Every delivery sets the status to send-pending. The status stays pending until the core returns a one-cycle acceptance pulse. While the status is pending, further source events are dropped. This means a source can have at most one interrupt outstanding at the core.

Top module: `irq_entry_dispatch`

## Requirements
- R1: After reset, `cfgRdData` reads all zero and every output toward the core and the external controller is low.
- R2: A write places `cfgWrData[VEC_W-1:0]` in the vector field and `cfgWrData[VEC_W+2:VEC_W]` in the mode field. The read port shows them at the same positions, shows the status at bit `VEC_W+4`, and shows zero on all other bits. Write data at the status position has no effect on the status.
- R3: Mode 3'b000 (fixed): a source event sampled at a clock edge gives, after that edge, a one-cycle `coreVecValid` with `coreVector` equal to the entry vector and `coreExtFlag` low.
- R4: Mode 3'b010 gives a one-cycle `coreSmi`, mode 3'b100 gives a one-cycle `coreNmi`, and mode 3'b101 gives a one-cycle `coreInit`. In all three modes `coreVecValid` stays low.
- R5: The status becomes 1 at the same edge that starts a delivery. It stays 1 until a `coreAccept` pulse is sampled while no acknowledge cycle is open, and it then reads 0 after that edge.
- R6: A source event sampled while the status is 1, including one in the same cycle as `coreAccept`, delivers nothing.
- R7: Codes 3'b001, 3'b011 and 3'b110 are reserved. An event under a reserved code raises no output and leaves the status at 0.
- R8: Mode 3'b111 (external controller): after the event edge, `extAckReq` goes high and stays high until `extVecValid` is sampled. After that edge, `extAckReq` is low and `coreVecValid` pulses for one cycle with `coreVector` equal to the sampled `extVector` and `coreExtFlag` high.
- R9: A `coreAccept` pulse that arrives while `extAckReq` is high has no effect, and the status stays 1.
- R10: At most one of `coreVecValid`, `coreSmi`, `coreNmi` and `coreInit` is high in any cycle, and none of them is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Entry write strobe |
| cfgWrData | input | VEC_W+5 | Entry write data |
| cfgRdData | output | VEC_W+5 | Entry readback including status |
| srcEvent | input | 1 | Interrupt event from the local source |
| coreAccept | input | 1 | One-cycle acceptance pulse from the core |
| coreVecValid | output | 1 | Vectored interrupt pulse to the core |
| coreVector | output | VEC_W | Vector sent with `coreVecValid` |
| coreExtFlag | output | 1 | Marks the vector as supplied by the external controller |
| coreSmi | output | 1 | System-management interrupt pulse |
| coreNmi | output | 1 | Non-maskable interrupt pulse |
| coreInit | output | 1 | INIT request pulse |
| extAckReq | output | 1 | Acknowledge request to the external controller |
| extVecValid | input | 1 | External controller vector strobe |
| extVector | input | VEC_W | Vector returned by the external controller |

## Verification
The bound checker watches every cycle for the following properties:
- the core pulses are mutually exclusive and each lasts one cycle;
- no core pulse appears without the pending status;
- the status never changes without an event or an acceptance;
- an acceptance outside an acknowledge cycle clears the status;
- the acknowledge request holds until the strobe and then returns the strobed vector;
- reserved codes never raise the status.

Some properties can only be shown by the bench's scenarios. These are that the right line is chosen for each mode code, that the fixed mode carries the written vector, that the read port returns the written fields while ignoring the status bit, and that an event in the same cycle as an acceptance is dropped.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam logic [2:0] MODE_FIXED = 3'b000;
  localparam logic [2:0] MODE_SMI   = 3'b010;
  localparam logic [2:0] MODE_NMI   = 3'b100;
  localparam logic [2:0] MODE_INIT  = 3'b101;
  localparam logic [2:0] MODE_EXT   = 3'b111;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_FIXED,
    KIND_SMI,
    KIND_NMI,
    KIND_INIT,
    KIND_EXT
  } kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic fireFixed;
    logic fireSmi;
    logic fireNmi;
    logic fireInit;
    logic ackStart;
    logic ackDone;
  } strobes_t;

  function automatic kind_e decodeMode(input logic [2:0] mode);
    case (mode)
      MODE_FIXED: decodeMode = KIND_FIXED;
      MODE_SMI:   decodeMode = KIND_SMI;
      MODE_NMI:   decodeMode = KIND_NMI;
      MODE_INIT:  decodeMode = KIND_INIT;
      MODE_EXT:   decodeMode = KIND_EXT;
      default:    decodeMode = KIND_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWrEn,
  input  logic     srcEvent,
  input  logic     coreAccept,
  input  logic     extVecValid,
  input  kind_e    modeKind,
  output strobes_t strobes,
  output logic     statusBit
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e state;

  logic takeEvent;

  // An event is taken only when idle, not pending, and under a known code
  assign takeEvent = (state == ST_IDLE) && !statusBit && srcEvent
                     && (modeKind != KIND_NONE);

  always_comb begin
    strobes           = '0;
    strobes.cfgLoad   = cfgWrEn;
    strobes.fireFixed = takeEvent && (modeKind == KIND_FIXED);
    strobes.fireSmi   = takeEvent && (modeKind == KIND_SMI);
    strobes.fireNmi   = takeEvent && (modeKind == KIND_NMI);
    strobes.fireInit  = takeEvent && (modeKind == KIND_INIT);
    strobes.ackStart  = takeEvent && (modeKind == KIND_EXT);
    strobes.ackDone   = (state == ST_WAIT) && extVecValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      statusBit <= 1'b0;
    end else begin
      if (strobes.ackStart)     state <= ST_WAIT;
      else if (strobes.ackDone) state <= ST_IDLE;

      if (takeEvent)                                statusBit <= 1'b1;
      else if (coreAccept && (state == ST_IDLE))    statusBit <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int VEC_W = 8,
  localparam int CFG_W = VEC_W + 5,
  localparam int STAT_POS = VEC_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [VEC_W-1:0] extVector,
  input  logic             statusBit,
  output logic [CFG_W-1:0] cfgRdData,
  output kind_e            modeKind,
  output logic             coreVecValid,
  output logic [VEC_W-1:0] coreVector,
  output logic             coreExtFlag,
  output logic             coreSmi,
  output logic             coreNmi,
  output logic             coreInit,
  output logic             extAckReq
);

  logic [VEC_W-1:0] vecReg;
  logic [2:0]       modeReg;
  logic             unusedWrBits;

  // Status position and spare bits of the write word are not stored
  assign unusedWrBits = ^cfgWrData[CFG_W-1:VEC_W+3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg  <= '0;
      modeReg <= '0;
    end else if (strobes.cfgLoad) begin
      vecReg  <= cfgWrData[VEC_W-1:0];
      modeReg <= cfgWrData[VEC_W+2:VEC_W];
    end
  end

  assign modeKind = decodeMode(modeReg);

  always_comb begin
    cfgRdData                    = '0;
    cfgRdData[VEC_W-1:0]         = vecReg;
    cfgRdData[VEC_W+2:VEC_W]     = modeReg;
    cfgRdData[STAT_POS]          = statusBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreVecValid <= 1'b0;
      coreVector   <= '0;
      coreExtFlag  <= 1'b0;
      coreSmi      <= 1'b0;
      coreNmi      <= 1'b0;
      coreInit     <= 1'b0;
      extAckReq    <= 1'b0;
    end else begin
      coreVecValid <= strobes.fireFixed | strobes.ackDone;
      coreSmi      <= strobes.fireSmi;
      coreNmi      <= strobes.fireNmi;
      coreInit     <= strobes.fireInit;
      if (strobes.ackDone) begin
        coreVector  <= extVector;
        coreExtFlag <= 1'b1;
      end else if (strobes.fireFixed) begin
        coreVector  <= vecReg;
        coreExtFlag <= 1'b0;
      end
      if (strobes.ackStart)     extAckReq <= 1'b1;
      else if (strobes.ackDone) extAckReq <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_entry_dispatch.sv
module irq_entry_dispatch
  import irq_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [VEC_W+4:0]   cfgWrData,
  output logic [VEC_W+4:0]   cfgRdData,
  input  logic               srcEvent,
  input  logic               coreAccept,
  output logic               coreVecValid,
  output logic [VEC_W-1:0]   coreVector,
  output logic               coreExtFlag,
  output logic               coreSmi,
  output logic               coreNmi,
  output logic               coreInit,
  output logic               extAckReq,
  input  logic               extVecValid,
  input  logic [VEC_W-1:0]   extVector
);

  strobes_t strobes;
  kind_e    modeKind;
  logic     statusBit;

  irq_entry_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .srcEvent    (srcEvent),
    .coreAccept  (coreAccept),
    .extVecValid (extVecValid),
    .modeKind    (modeKind),
    .strobes     (strobes),
    .statusBit   (statusBit)
  );

  irq_entry_dp #(.VEC_W(VEC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cfgWrData    (cfgWrData),
    .extVector    (extVector),
    .statusBit    (statusBit),
    .cfgRdData    (cfgRdData),
    .modeKind     (modeKind),
    .coreVecValid (coreVecValid),
    .coreVector   (coreVector),
    .coreExtFlag  (coreExtFlag),
    .coreSmi      (coreSmi),
    .coreNmi      (coreNmi),
    .coreInit     (coreInit),
    .extAckReq    (extAckReq)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [VEC_W+4:0] cfgRdData,
  input logic             srcEvent,
  input logic             coreAccept,
  input logic             coreVecValid,
  input logic [VEC_W-1:0] coreVector,
  input logic             coreExtFlag,
  input logic             coreSmi,
  input logic             coreNmi,
  input logic             coreInit,
  input logic             extAckReq,
  input logic             extVecValid,
  input logic [VEC_W-1:0] extVector
);

  logic       pend;
  logic [2:0] modeF;
  logic       anyPulse;
  logic       resvMode;

  assign pend     = cfgRdData[VEC_W+4];
  assign modeF    = cfgRdData[VEC_W+2:VEC_W];
  assign anyPulse = coreVecValid | coreSmi | coreNmi | coreInit;
  assign resvMode = (modeF == 3'b001) || (modeF == 3'b011) || (modeF == 3'b110);

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({coreVecValid, coreSmi, coreNmi, coreInit}));

  a_r10_vec_single: assert property (@(posedge clk) disable iff (!rstN)
    coreVecValid |=> !coreVecValid);

  a_r10_line_single: assert property (@(posedge clk) disable iff (!rstN)
    (coreSmi | coreNmi | coreInit) |=> !(coreSmi | coreNmi | coreInit));

  a_r5_pulse_pending: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |-> pend);

  a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rstN)
    (coreAccept && pend && !extAckReq) |=> !pend);

  a_r2_status_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!srcEvent && !coreAccept) |=> $stable(pend));

  a_r6_no_redeliver: assert property (@(posedge clk) disable iff (!rstN)
    pend |=> !(coreSmi || coreNmi || coreInit || (coreVecValid && !coreExtFlag)));

  a_r7_reserved_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!pend && !extAckReq && resvMode) |=> !pend);

  a_r8_ack_hold: assert property (@(posedge clk) disable iff (!rstN)
    (extAckReq && !extVecValid) |=> extAckReq);

  a_r8_ack_vector: assert property (@(posedge clk) disable iff (!rstN)
    (extAckReq && extVecValid) |=>
      (coreVecValid && coreExtFlag && !extAckReq && coreVector == $past(extVector)));

  a_r9_accept_ignored: assert property (@(posedge clk) disable iff (!rstN)
    extAckReq |=> pend);

endmodule

bind irq_entry_dispatch irq_entry_chk #(.VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgRdData    (cfgRdData),
  .srcEvent     (srcEvent),
  .coreAccept   (coreAccept),
  .coreVecValid (coreVecValid),
  .coreVector   (coreVector),
  .coreExtFlag  (coreExtFlag),
  .coreSmi      (coreSmi),
  .coreNmi      (coreNmi),
  .coreInit     (coreInit),
  .extAckReq    (extAckReq),
  .extVecValid  (extVecValid),
  .extVector    (extVector)
);

// File: tb/sim_irq_entry_dispatch.sv
module sim_irq_entry_dispatch;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 8;
  localparam int CFG_W = VEC_W + 5;
  localparam int STAT = VEC_W + 4;
  localparam int WATCHDOG = 20000;

  localparam int K_NONE = 0, K_FIXED = 1, K_SMI = 2, K_NMI = 3, K_INIT = 4, K_EXT = 5;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cfgWrEn;
  logic [CFG_W-1:0] cfgWrData;
  logic [CFG_W-1:0] cfgRdData;
  logic             srcEvent;
  logic             coreAccept;
  logic             coreVecValid;
  logic [VEC_W-1:0] coreVector;
  logic             coreExtFlag;
  logic             coreSmi;
  logic             coreNmi;
  logic             coreInit;
  logic             extAckReq;
  logic             extVecValid;
  logic [VEC_W-1:0] extVector;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  irq_entry_dispatch #(.VEC_W(VEC_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .srcEvent(srcEvent), .coreAccept(coreAccept),
    .coreVecValid(coreVecValid), .coreVector(coreVector), .coreExtFlag(coreExtFlag),
    .coreSmi(coreSmi), .coreNmi(coreNmi), .coreInit(coreInit),
    .extAckReq(extAckReq), .extVecValid(extVecValid), .extVector(extVector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int expKind(input logic [2:0] m);
    case (m)
      3'b000: return K_FIXED;
      3'b010: return K_SMI;
      3'b100: return K_NMI;
      3'b101: return K_INIT;
      3'b111: return K_EXT;
      default: return K_NONE;
    endcase
  endfunction

  function automatic int lines();
    return {coreVecValid, coreSmi, coreNmi, coreInit};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeEntry(input logic [2:0] m, input logic [VEC_W-1:0] v, input bit statBit);
    logic [CFG_W-1:0] exp;
    cfgWrEn = 1'b1;
    cfgWrData = '0;
    cfgWrData[VEC_W-1:0] = v;
    cfgWrData[VEC_W+2:VEC_W] = m;
    cfgWrData[STAT] = statBit;
    cfgWrData[VEC_W+3] = 1'b1;
    step();
    cfgWrEn = 1'b0;
    exp = '0;
    exp[VEC_W-1:0] = v;
    exp[VEC_W+2:VEC_W] = m;
    chk(cfgRdData == exp, "R2 readback", int'(cfgRdData), int'(exp));
  endtask

  // Fires one event from an idle, non-pending state and checks the outcome
  task automatic runEvent(input logic [2:0] m, input logic [VEC_W-1:0] v, input int waitCyc,
                          input bit retrigger);
    int k;
    int expLines;
    logic [VEC_W-1:0] rv;
    k = expKind(m);
    srcEvent = 1'b1;
    step();
    srcEvent = 1'b0;
    case (k)
      K_FIXED: expLines = 4'b1000;
      K_SMI:   expLines = 4'b0100;
      K_NMI:   expLines = 4'b0010;
      K_INIT:  expLines = 4'b0001;
      default: expLines = 0;
    endcase
    if (k == K_NONE) begin
      chk(lines() == 0, "R7 reserved no output", lines(), 0);
      chk(cfgRdData[STAT] == 1'b0, "R7 reserved status idle", cfgRdData[STAT], 0);
      chk(extAckReq == 1'b0, "R7 reserved no ack", extAckReq, 0);
      return;
    end
    chk(cfgRdData[STAT] == 1'b1, "R5 status set", cfgRdData[STAT], 1);
    if (k == K_FIXED) begin
      chk(lines() == expLines, "R3 fixed line", lines(), expLines);
      chk(coreVector == v && !coreExtFlag, "R3 fixed vector", coreVector, v);
    end else if (k == K_EXT) begin
      chk(extAckReq && lines() == 0, "R8 ack raised", {extAckReq, 4'(lines())}, 5'h10);
      for (int i = 0; i < waitCyc; i++) begin
        coreAccept = (i == 0);
        step();
        coreAccept = 1'b0;
        chk(extAckReq && lines() == 0, "R8 ack held", {extAckReq, 4'(lines())}, 5'h10);
        chk(cfgRdData[STAT] == 1'b1, "R9 accept ignored", cfgRdData[STAT], 1);
      end
      rv = VEC_W'($urandom);
      extVecValid = 1'b1;
      extVector = rv;
      step();
      extVecValid = 1'b0;
      extVector = VEC_W'($urandom);
      chk(coreVecValid && coreExtFlag && !extAckReq, "R8 ext delivery",
          {coreVecValid, coreExtFlag, extAckReq}, 3'b110);
      chk(coreVector == rv, "R8 ext vector", coreVector, rv);
    end else begin
      chk(lines() == expLines, "R4 line select", lines(), expLines);
    end
    step();
    chk(lines() == 0, "R10 single cycle pulse", lines(), 0);
    if (retrigger) begin
      srcEvent = 1'b1;
      step();
      srcEvent = 1'b0;
      chk(lines() == 0 && !extAckReq, "R6 dropped while pending", lines(), 0);
      // event together with acceptance is also dropped
      srcEvent = 1'b1;
      coreAccept = 1'b1;
      step();
      srcEvent = 1'b0;
      coreAccept = 1'b0;
      chk(lines() == 0 && !extAckReq, "R6 dropped at accept", lines(), 0);
      chk(cfgRdData[STAT] == 1'b0, "R5 accept clears", cfgRdData[STAT], 0);
    end else begin
      coreAccept = 1'b1;
      step();
      coreAccept = 1'b0;
      chk(cfgRdData[STAT] == 1'b0, "R5 accept clears", cfgRdData[STAT], 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0;
    cfgWrEn = 1'b0;
    cfgWrData = '0;
    srcEvent = 1'b0;
    coreAccept = 1'b0;
    extVecValid = 1'b0;
    extVector = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();

    chk(cfgRdData == '0, "R1 reset readback", int'(cfgRdData), 0);
    chk(lines() == 0 && !extAckReq, "R1 reset outputs", {extAckReq, 4'(lines())}, 0);

    // Directed cases
    writeEntry(3'b000, 8'hA5, 1'b1);
    chk(cfgRdData[STAT] == 1'b0, "R2 status not writable", cfgRdData[STAT], 0);
    runEvent(3'b000, 8'hA5, 0, 1'b1);
    writeEntry(3'b010, 8'h00, 1'b0);
    runEvent(3'b010, 8'h00, 0, 1'b0);
    writeEntry(3'b100, 8'h77, 1'b0);
    runEvent(3'b100, 8'h77, 0, 1'b1);
    writeEntry(3'b101, 8'h00, 1'b0);
    runEvent(3'b101, 8'h00, 0, 1'b0);
    writeEntry(3'b011, 8'h12, 1'b0);
    runEvent(3'b011, 8'h12, 0, 1'b0);
    writeEntry(3'b111, 8'h00, 1'b0);
    runEvent(3'b111, 8'h00, 3, 1'b1);
    writeEntry(3'b111, 8'h00, 1'b0);
    runEvent(3'b111, 8'h00, 0, 1'b0);

    // Constrained random mix
    for (int n = 0; n < 60; n++) begin
      logic [2:0] m;
      logic [VEC_W-1:0] v;
      m = 3'($urandom);
      v = VEC_W'($urandom);
      writeEntry(m, v, 1'($urandom));
      runEvent(m, v, int'($urandom % 4), 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule